// File: doc/BRIEF.md
# Laser Enable and Fault Latch Controller

This block decides, every clock cycle, whether the transmit laser of an optical module may emit. Two disable sources feed it: the host-driven disable pin, which arrives asynchronously, and a disable bit held in the module's management registers. Either source turns the laser off. A fault-detect line from the laser driver is synchronised and filtered. A fault that persists long enough is latched, raises the fault pin, and holds the laser off until the host clears it.

Software cannot clear a latched fault. The only way to clear it is to hold the disable pin high for a programmable number of ticks of a slow reference strobe. Once the laser has been enabled, a second tick counter measures the start-up interval. The block then raises a ready flag that marks the transmitter as fully operational. Two status outputs carry the synchronised pin level and the fault state to the management register file.

Top module: `laser_guard`

## Requirements
- R1: While rst_n is low, laser_en, fault_out, ready and stat_fault are 0, and stat_dis_pin is 1, because the pin synchroniser resets to the disabled state as a floating pin would.
- R2: laser_en goes low on the (SYNC_STAGES+1)-th rising clock edge after tx_dis_pin rises. When no other hold-off is active, it returns high on the (SYNC_STAGES+1)-th edge after the pin falls.
- R3: laser_en goes low on the first edge after soft_dis rises. The two disable sources are ORed, so the laser stays off while either one is high.
- R4: fault_det latches a fault only after it has been seen high for FAULT_PERSIST consecutive synchronised samples. fault_out then rises on edge SYNC_STAGES+FAULT_PERSIST after fault_det rises. Shorter pulses leave fault_out low.
- R5: A latched fault keeps fault_out high after fault_det returns low. laser_en is low from the edge after the latch, whatever the state of the disable sources, and toggling soft_dis does not clear the fault.
- R6: A latched fault clears on the edge at which RESET_TICKS tick strobes have been counted while the synchronised pin stays high. With tick held high, a pin held for RESET_TICKS sampled edges clears the fault, and fault_out falls on edge RESET_TICKS+SYNC_STAGES after the pin rises. A shorter hold leaves the fault latched, and cycles with tick low are not counted.
- R7: stat_dis_pin is the synchronised pin level, following tx_dis_pin after SYNC_STAGES edges and unaffected by soft_dis. stat_fault equals fault_out.
- R8: ready rises on the edge at which STARTUP_TICKS tick strobes have been counted since laser_en rose. It falls on the edge after laser_en goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle timing strobe used by the reset-hold and start-up counters |
| tx_dis_pin | input | 1 | Host disable pin level, asynchronous |
| soft_dis | input | 1 | Disable bit from the management registers, synchronous |
| fault_det | input | 1 | Fault indication from the laser driver, asynchronous |
| laser_en | output | 1 | Laser emission enable |
| fault_out | output | 1 | Latched fault level for the host fault pin |
| ready | output | 1 | Transmitter fully operational after the start-up interval |
| stat_dis_pin | output | 1 | Synchronised disable pin level for the status register |
| stat_fault | output | 1 | Fault state for the status register |

## Verification
Each result has a fixed offset from the stimulus that causes it. The laser turns off three edges after a pin change and one edge after a soft-disable change. The fault pin rises two synchroniser edges plus the persistence count after the fault line rises, and falls two edges plus the hold count after the pin rises. The ready flag follows the start-up count of ticks after the enable. The bench drives all inputs on falling edges and counts rising edges from the stimulus to sample exactly at those offsets. It also samples one edge earlier to confirm that nothing changes too soon. The pulse length and the hold length are swept across the thresholds of a small configuration, and the latch or clear result expected at each length is computed from those thresholds.

// File: rtl/txg_pkg.sv
`timescale 1ns/1ps
package txg_pkg;

    // Per-cycle control events feeding the state update of the controller.
    typedef struct packed {
        logic dis_any;   // either disable source active
        logic flt_qual;  // fault has persisted long enough to latch
        logic clr_hit;   // reset-hold count reached on this edge
        logic su_hit;    // start-up count reached on this edge
    } ctl_evt_t;

endpackage

// File: rtl/txg_sync.sv
`timescale 1ns/1ps
module txg_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic s_d, s_q;
            always_comb s_d = d;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= RESET_VAL;
                else        s_q <= s_d;
            end
            assign q = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] s_d, s_q;
            always_comb s_d = {s_q[STAGES-2:0], d};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= {STAGES{RESET_VAL}};
                else        s_q <= s_d;
            end
            assign q = s_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/txg_persist.sv
`timescale 1ns/1ps
module txg_persist #(
    parameter int PERSIST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic qual
);

    localparam int PW = (PERSIST > 1) ? $clog2(PERSIST) : 1;
    localparam logic [PW-1:0] LAST = PW'(PERSIST - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    // Count consecutive high samples, saturating at the qualifying value.
    always_comb begin
        if (!lvl)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign qual = lvl && (cnt_q == LAST);

endmodule

// File: rtl/txg_tick_cnt.sv
`timescale 1ns/1ps
module txg_tick_cnt #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic hit
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    // Counts ticks while run is high; cleared when run drops; saturates at LIMIT.
    always_comb begin
        if (!run)                     cnt_d = '0;
        else if (tick && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
        else                          cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // One-cycle pulse on the edge at which the count reaches LIMIT.
    assign hit = run && tick && (cnt_q == LAST);

endmodule

// File: rtl/laser_guard.sv
`timescale 1ns/1ps
module laser_guard
    import txg_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int FAULT_PERSIST = 8,
    parameter int RESET_TICKS   = 10,
    parameter int STARTUP_TICKS = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_dis_pin,
    input  logic soft_dis,
    input  logic fault_det,
    output logic laser_en,
    output logic fault_out,
    output logic ready,
    output logic stat_dis_pin,
    output logic stat_fault
);

    typedef struct packed {
        logic laser_en;
        logic fault;
        logic ready;
    } st_t;

    logic     dis_s, flt_s;
    logic     qual, clr_hit, su_hit;
    ctl_evt_t evt;
    st_t      st_d, st_q;

    // Pin synchroniser resets high: an undriven pin means "disabled".
    txg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_dis_sync (
        .clk(clk), .rst_n(rst_n), .d(tx_dis_pin), .q(dis_s)
    );

    txg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_flt_sync (
        .clk(clk), .rst_n(rst_n), .d(fault_det), .q(flt_s)
    );

    txg_persist #(.PERSIST(FAULT_PERSIST)) u_persist (
        .clk(clk), .rst_n(rst_n), .lvl(flt_s), .qual(qual)
    );

    // Reset-hold timer: runs only while the pin itself is held.
    txg_tick_cnt #(.LIMIT(RESET_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .run(dis_s), .tick(tick), .hit(clr_hit)
    );

    // Start-up timer: runs while the laser is enabled.
    txg_tick_cnt #(.LIMIT(STARTUP_TICKS)) u_startup (
        .clk(clk), .rst_n(rst_n), .run(st_q.laser_en), .tick(tick), .hit(su_hit)
    );

    always_comb begin
        evt.dis_any  = dis_s | soft_dis;
        evt.flt_qual = qual;
        evt.clr_hit  = clr_hit;
        evt.su_hit   = su_hit;

        st_d = st_q;
        // A new qualified fault wins over a clear on the same edge.
        if (evt.flt_qual)     st_d.fault = 1'b1;
        else if (evt.clr_hit) st_d.fault = 1'b0;
        st_d.laser_en = !evt.dis_any && !st_q.fault;
        st_d.ready    = st_q.laser_en && (evt.su_hit || st_q.ready);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign laser_en     = st_q.laser_en;
    assign fault_out    = st_q.fault;
    assign ready        = st_q.ready;
    assign stat_dis_pin = dis_s;
    assign stat_fault   = st_q.fault;

endmodule

// File: rtl/laser_guard_chk.sv
`timescale 1ns/1ps
module laser_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_dis,
    input logic stat_dis_pin,
    input logic flt_lvl,
    input logic laser_en,
    input logic fault_out,
    input logic ready
);

    // R2
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_dis_pin |=> !laser_en);

    // R3
    soft_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_dis |=> !laser_en);

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_out |=> !laser_en);

    // R4
    fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_out) |-> $past(flt_lvl));

    // R6
    fault_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_out) |-> $past(stat_dis_pin));

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !laser_en |=> !ready);

endmodule

bind laser_guard laser_guard_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .soft_dis(soft_dis),
    .stat_dis_pin(stat_dis_pin),
    .flt_lvl(flt_s),
    .laser_en(laser_en),
    .fault_out(fault_out),
    .ready(ready)
);

// File: tb/laser_guard_bench.sv
`timescale 1ns/1ps
module laser_guard_bench;

    localparam int SY = 2;
    localparam int PR = 3;
    localparam int RT = 4;
    localparam int ST = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic tx_dis_pin = 1'b0;
    logic soft_dis = 1'b0;
    logic fault_det = 1'b0;
    logic laser_en, fault_out, ready, stat_dis_pin, stat_fault;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    laser_guard #(
        .SYNC_STAGES(SY), .FAULT_PERSIST(PR),
        .RESET_TICKS(RT), .STARTUP_TICKS(ST)
    ) u_laser_guard (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tx_dis_pin(tx_dis_pin), .soft_dis(soft_dis), .fault_det(fault_det),
        .laser_en(laser_en), .fault_out(fault_out), .ready(ready),
        .stat_dis_pin(stat_dis_pin), .stat_fault(stat_fault)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Latch a fault with a qualifying pulse and let the sync chain drain.
    task automatic latch_fault();
        fault_det = 1'b1;
        step(PR);
        fault_det = 1'b0;
        step(SY + 3);
    endtask

    initial begin
        step(3);
        // R1: reset values
        check("R1 laser_en", laser_en, 1'b0);
        check("R1 fault_out", fault_out, 1'b0);
        check("R1 ready", ready, 1'b0);
        check("R1 stat_fault", stat_fault, 1'b0);
        check("R1 stat_dis_pin", stat_dis_pin, 1'b1);

        rst_n = 1'b1;
        step(SY);
        check("R2 enable not before sync", laser_en, 1'b0);
        check("R7 pin status low", stat_dis_pin, 1'b0);
        step(1);
        check("R2 enable after reset", laser_en, 1'b1);
        step(ST - 1);
        check("R8 ready early", ready, 1'b0);
        step(1);
        check("R8 ready on time", ready, 1'b1);

        // R2 pin disable and release
        tx_dis_pin = 1'b1;
        step(SY);
        check("R2 still on", laser_en, 1'b1);
        check("R7 pin status high", stat_dis_pin, 1'b1);
        step(1);
        check("R2 off", laser_en, 1'b0);
        step(1);
        check("R8 ready drop", ready, 1'b0);
        tx_dis_pin = 1'b0;
        step(SY);
        check("R2 still off", laser_en, 1'b0);
        step(1);
        check("R2 back on", laser_en, 1'b1);
        step(ST);
        check("R8 ready after re-enable", ready, 1'b1);

        // R3 soft disable and OR with pin
        soft_dis = 1'b1;
        step(1);
        check("R3 soft off", laser_en, 1'b0);
        check("R7 soft not mirrored", stat_dis_pin, 1'b0);
        soft_dis = 1'b0;
        step(1);
        check("R3 soft release", laser_en, 1'b1);
        tx_dis_pin = 1'b1;
        step(SY + 1);
        soft_dis = 1'b1;
        tx_dis_pin = 1'b0;
        step(SY + 2);
        check("R3 soft holds off after pin release", laser_en, 1'b0);
        soft_dis = 1'b0;
        step(1);
        check("R3 both released", laser_en, 1'b1);
        step(2);

        // R4 exact latch timing, R5 latch behaviour
        fault_det = 1'b1;
        step(SY + PR - 1);
        check("R4 no early fault", fault_out, 1'b0);
        step(1);
        check("R4 fault on time", fault_out, 1'b1);
        check("R7 stat_fault", stat_fault, 1'b1);
        check("R5 enable one edge later", laser_en, 1'b1);
        step(1);
        check("R5 laser off on fault", laser_en, 1'b0);
        fault_det = 1'b0;
        step(SY + 1);
        soft_dis = 1'b1;
        step(2);
        soft_dis = 1'b0;
        step(3);
        check("R5 fault persists", fault_out, 1'b1);
        check("R5 laser held off", laser_en, 1'b0);

        // R6 exact clear timing
        tx_dis_pin = 1'b1;
        step(RT);
        tx_dis_pin = 1'b0;
        step(SY - 1);
        check("R6 no early clear", fault_out, 1'b1);
        step(1);
        check("R6 clear on time", fault_out, 1'b0);
        step(1);
        check("R2 enable after clear", laser_en, 1'b1);
        step(2);

        // R4 pulse length sweep
        for (int n = 1; n <= PR + 2; n++) begin
            fault_det = 1'b1;
            step(n);
            fault_det = 1'b0;
            step(SY + PR + 1);
            check("R4 pulse sweep", fault_out, (n >= PR));
            check("R5 enable vs pulse", laser_en, !(n >= PR));
            if (n >= PR) begin
                tx_dis_pin = 1'b1;
                step(RT);
                tx_dis_pin = 1'b0;
                step(SY + 2);
                check("R6 sweep clear", fault_out, 1'b0);
                check("R2 sweep re-enable", laser_en, 1'b1);
            end
            step(2);
        end

        // R6 hold length sweep
        for (int l = 1; l <= RT + 2; l++) begin
            latch_fault();
            check("R5 latched before hold", fault_out, 1'b1);
            tx_dis_pin = 1'b1;
            step(l);
            tx_dis_pin = 1'b0;
            step(SY + 3);
            check("R6 hold sweep", fault_out, !(l >= RT));
            step(2);
        end

        // R6 ticks gate the hold count
        latch_fault();
        tick = 1'b0;
        tx_dis_pin = 1'b1;
        step(2 * RT);
        tx_dis_pin = 1'b0;
        step(SY + 3);
        check("R6 no ticks no clear", fault_out, 1'b1);
        tick = 1'b1;
        tx_dis_pin = 1'b1;
        step(RT);
        tx_dis_pin = 1'b0;
        step(SY + 3);
        check("R6 clear with ticks", fault_out, 1'b0);

        // R8 ready after fault recovery: laser rose SY+1 edges after pin fall
        step(SY + 1 + ST - 1 - (SY + 3));
        check("R8 not ready yet", ready, 1'b0);
        step(1);
        check("R8 ready after recovery", ready, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule